// File: doc/BRIEF.md
# Converter bus interface sequencer

This block is the digital control side of a sampling analog-to-digital converter that sits on a processor bus as a plain memory location. A host starts a conversion with an active-low sample strobe, reads the result with an active-low read strobe, and learns that a result is ready from an active-low interrupt. The block turns these bus events into four internal phase controls: sample, coarse compare, fine compare and latch. The analog front end uses these controls. A digital result arrives on a stub port and is captured during the latch phase. Cycle counters set all internal conversion timing.

Two start styles are supported, selected by `tied_mode` when a conversion starts. In the strobe-started style, the coarse step lasts as long as the sample strobe is held low. The rising edge of the strobe ends the coarse step and starts a fine step of fixed length. In the read-started style, the sample and read strobes are wired together. A single falling edge starts a timed coarse step, then a timed fine step. During that conversion the bus keeps presenting the previous result, and the new one appears a fixed number of cycles after the interrupt falls. The selected analog channel is captured at the start. A sticky flag reports a sample strobe pulse that is too short, and another sticky flag reports a start request that arrives while a conversion is still running.

Top module: `conv_bus_seq`

## Requirements
- R1: A synchronous reset drives `int_n` high, turns the bus driver off, clears the stored result to zero and clears both sticky flags. A read after reset returns 0.
- R2: The sample and read strobes act only while `cs_n` is low. Strobe activity with `cs_n` high starts nothing and changes no output.
- R3: The channel output takes the value of `chan_sel` in the cycle where the chip-select-gated sample strobe first goes low and no conversion is running. The values 0, 1, 2 and 3 select inputs 0 to 3. The channel then holds until the next accepted start.
- R4: In strobe-started mode, the coarse phase is high from the cycle after the gated strobe falls until the cycle the strobe is seen high again. Fine is then high for FINE_CYC cycles, then latch for one cycle, and `int_n` goes low in the cycle after the latch.
- R5: `int_n` returns high in the cycle after the chip-select-gated read strobe is seen rising, unless a latch happens in that same cycle.
- R6: `dbus_oe` is high exactly while `cs_n` and `rd_n` are both low and reset is inactive. While it is high, `dbus` carries the stored result; otherwise `dbus` is high impedance.
- R7: In read-started mode, coarse is high for RCOARSE_CYC cycles from the cycle after the start, and fine is then high for RFINE_CYC cycles, whatever the strobe level.
- R8: In read-started mode, the bus shows the previous result during the conversion and shows the new result VALID_DLY cycles after `int_n` falls.
- R9: In strobe-started mode, the stored result changes at the same clock edge at which `int_n` falls.
- R10: If the gated sample strobe is low for fewer than MIN_SH_CYC cycles in strobe-started mode, `sh_short` is set and stays set until reset.
- R11: A gated sample strobe fall while a conversion is running is ignored. Timing and channel are not affected, and `overrun` is set and stays set until reset.
- R12: At most one of coarse, fine and latch is high in any cycle, and `ph_sample` is high only while coarse is high and the gated sample strobe is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Chip select, active low |
| sh_n | input | 1 | Sample strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| tied_mode | input | 1 | 1 selects read-started mode, taken at start |
| chan_sel | input | CHW | Channel select lines |
| result_in | input | DW | Conversion result from the analog stub |
| int_n | output | 1 | End-of-conversion interrupt, active low |
| dbus | output | DW | Tri-stated result bus |
| dbus_oe | output | 1 | Bus driver enable |
| chan | output | CHW | Captured channel for the input mux |
| ph_sample | output | 1 | Sampling switch control |
| ph_coarse | output | 1 | Coarse compare phase |
| ph_fine | output | 1 | Fine compare phase |
| ph_latch | output | 1 | Result latch pulse |
| sh_short | output | 1 | Sticky sample-time violation |
| overrun | output | 1 | Sticky start-while-busy flag |

## Verification
Several properties are checked on every cycle by assertions: the latch is always followed by the interrupt falling, the latch always follows a fine phase, the interrupt only rises after a gated read edge, the channel holds through the fine phase, and both sticky flags stay set. The exact phase lengths in each mode, the delayed result on the bus in read-started mode, the chip-select gating and the ignored start during a busy conversion can only be shown by the bench's scenarios. In those scenarios a behavioural model predicts every output cycle by cycle.

// File: rtl/conv_bus_seq.sv
module conv_bus_seq #(
  parameter int DW          = 10,
  parameter int CHW         = 2,
  parameter int MIN_SH_CYC  = 3,
  parameter int FINE_CYC    = 6,
  parameter int RCOARSE_CYC = 5,
  parameter int RFINE_CYC   = 8,
  parameter int VALID_DLY   = 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           cs_n,
  input  logic           sh_n,
  input  logic           rd_n,
  input  logic           tied_mode,
  input  logic [CHW-1:0] chan_sel,
  input  logic [DW-1:0]  result_in,
  output logic           int_n,
  output logic [DW-1:0]  dbus,
  output logic           dbus_oe,
  output logic [CHW-1:0] chan,
  output logic           ph_sample,
  output logic           ph_coarse,
  output logic           ph_fine,
  output logic           ph_latch,
  output logic           sh_short,
  output logic           overrun
);

  localparam int M1   = (FINE_CYC > RFINE_CYC) ? FINE_CYC : RFINE_CYC;
  localparam int M2   = (RCOARSE_CYC > VALID_DLY) ? RCOARSE_CYC : VALID_DLY;
  localparam int M3   = (M1 > M2) ? M1 : M2;
  localparam int MAXC = (M3 > MIN_SH_CYC) ? M3 : MIN_SH_CYC;
  localparam int CW   = $clog2(MAXC + 1);

  typedef enum logic [2:0] {S_IDLE, S_HOLD, S_TIMED, S_FINE, S_LATCH} st_t;

  st_t            st;
  logic           s_q, r_q, tmode, pend;
  logic [CW-1:0]  cnt, low_cnt, dcnt;
  logic [DW-1:0]  data_q, hold_q;

  wire s_g    = ~cs_n & ~sh_n;
  wire r_g    = ~cs_n & ~rd_n;
  wire s_fall = s_g & ~s_q;
  wire s_rise = ~s_g & s_q;
  wire r_rise = ~r_g & r_q;
  wire fine_last = tmode ? (cnt == CW'(RFINE_CYC - 1)) : (cnt == CW'(FINE_CYC - 1));

  assign ph_coarse = (st == S_HOLD) | (st == S_TIMED);
  assign ph_sample = ph_coarse & s_g;
  assign ph_fine   = (st == S_FINE);
  assign ph_latch  = (st == S_LATCH);
  assign dbus_oe   = r_g & ~rst;
  assign dbus      = dbus_oe ? data_q : 'z;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      s_q      <= 1'b0;
      r_q      <= 1'b0;
      tmode    <= 1'b0;
      pend     <= 1'b0;
      cnt      <= '0;
      low_cnt  <= '0;
      dcnt     <= '0;
      data_q   <= '0;
      hold_q   <= '0;
      chan     <= '0;
      int_n    <= 1'b1;
      sh_short <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      s_q <= s_g;
      r_q <= r_g;
      if (s_fall && st != S_IDLE) overrun <= 1'b1;
      if (pend) begin
        if (dcnt == CW'(VALID_DLY - 1)) begin
          data_q <= hold_q;
          pend   <= 1'b0;
        end else begin
          dcnt <= dcnt + 1'b1;
        end
      end
      if (r_rise) int_n <= 1'b1;
      case (st)
        S_IDLE: if (s_fall) begin
          chan    <= chan_sel;
          tmode   <= tied_mode;
          cnt     <= '0;
          low_cnt <= CW'(1);
          st      <= tied_mode ? S_TIMED : S_HOLD;
        end
        S_HOLD: begin
          if (s_rise) begin
            if (low_cnt < CW'(MIN_SH_CYC)) sh_short <= 1'b1;
            cnt <= '0;
            st  <= S_FINE;
          end else if (s_g && low_cnt != CW'(MIN_SH_CYC)) begin
            low_cnt <= low_cnt + 1'b1;
          end
        end
        S_TIMED: begin
          if (cnt == CW'(RCOARSE_CYC - 1)) begin
            cnt <= '0;
            st  <= S_FINE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_FINE: begin
          if (fine_last) st <= S_LATCH;
          else cnt <= cnt + 1'b1;
        end
        S_LATCH: begin
          int_n <= 1'b0;
          if (tmode) begin
            hold_q <= result_in;
            pend   <= 1'b1;
            dcnt   <= '0;
          end else begin
            data_q <= result_in;
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_latch_int_r4: assert property (@(posedge clk) disable iff (rst)
    ph_latch |=> !int_n);

  p_latch_after_fine_r4: assert property (@(posedge clk) disable iff (rst)
    ph_latch |-> $past(ph_fine));

  p_int_release_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(int_n) |-> $past(r_q && !r_g));

  p_chan_hold_r3: assert property (@(posedge clk) disable iff (rst)
    ph_fine |-> $stable(chan));

  p_short_sticky_r10: assert property (@(posedge clk) disable iff (rst)
    sh_short |=> sh_short);

  p_ovr_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

// File: tb/conv_bus_seq_bench.sv
module conv_bus_seq_bench;
  localparam int DW = 10, CHW = 2, MINS = 3, FC = 6, RC = 5, RF = 8, VD = 2;

  logic clk = 0, rst = 1, cs_n = 1, sh_n = 1, rd_n = 1, tied = 0;
  logic [CHW-1:0] chan_sel = '0;
  logic [DW-1:0]  result_in = '0;
  logic int_n, dbus_oe, ph_sample, ph_coarse, ph_fine, ph_latch, sh_short, overrun;
  logic [DW-1:0]  dbus;
  logic [CHW-1:0] chan;

  conv_bus_seq #(.DW(DW), .CHW(CHW), .MIN_SH_CYC(MINS), .FINE_CYC(FC),
                 .RCOARSE_CYC(RC), .RFINE_CYC(RF), .VALID_DLY(VD)) u_conv_bus_seq (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sh_n(sh_n), .rd_n(rd_n), .tied_mode(tied),
    .chan_sel(chan_sel), .result_in(result_in), .int_n(int_n), .dbus(dbus),
    .dbus_oe(dbus_oe), .chan(chan), .ph_sample(ph_sample), .ph_coarse(ph_coarse),
    .ph_fine(ph_fine), .ph_latch(ph_latch), .sh_short(sh_short), .overrun(overrun));

  always #2 clk = ~clk;

  int tests = 0, fails = 0, cycles = 0;
  bit go = 0;
  int m_ph = 0, m_left = 0, m_low = 0, m_int = 1, m_data = 0, m_hold = 0, m_pend = 0;
  int m_ovr = 0, m_viol = 0, m_ch = 0, m_md = 0, ps = 0, pr = 0;
  int last_res = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int sg, rg, sf, sr, rr;
    sg = (!cs_n && !sh_n) ? 1 : 0;
    rg = (!cs_n && !rd_n) ? 1 : 0;
    if (rst) begin
      m_ph = 0; m_int = 1; m_data = 0; m_hold = 0; m_pend = 0;
      m_ovr = 0; m_viol = 0; m_ch = 0; m_md = 0; ps = 0; pr = 0;
    end else begin
      sf = sg & ~ps; sr = ~sg & ps; rr = ~rg & pr;
      if (sf && m_ph != 0) m_ovr = 1;
      if (m_pend > 0) begin
        m_pend--;
        if (m_pend == 0) m_data = m_hold;
      end
      if (rr) m_int = 1;
      case (m_ph)
        0: if (sf) begin
             m_ch = chan_sel; m_md = tied;
             if (tied) begin m_ph = 2; m_left = RC; end
             else begin m_ph = 1; m_low = 1; end
           end
        1: if (sr) begin
             if (m_low < MINS) m_viol = 1;
             m_ph = 3; m_left = FC;
           end else if (sg) m_low++;
        2: begin m_left--; if (m_left == 0) begin m_ph = 3; m_left = RF; end end
        3: begin m_left--; if (m_left == 0) m_ph = 4; end
        default: begin
             m_int = 0;
             if (m_md) begin m_hold = result_in; m_pend = VD; end
             else m_data = result_in;
             m_ph = 0;
           end
      endcase
      ps = sg; pr = rg;
    end
  end

  always @(negedge clk) begin
    bit eoe;
    cycles++;
    if (go) begin
      eoe = !cs_n && !rd_n && !rst;
      chk(int_n == m_int[0], m_int ? "R5 int_n" : "R4 int_n", int_n, m_int);
      chk(dbus_oe == eoe, "R6 dbus_oe", dbus_oe, eoe);
      if (eoe && dbus_oe) chk(dbus == m_data[DW-1:0], m_md ? "R8 dbus" : "R9 dbus", dbus, m_data);
      chk(chan == m_ch[CHW-1:0], "R3 chan", chan, m_ch);
      chk(overrun == m_ovr[0], "R11 overrun", overrun, m_ovr);
      chk(sh_short == m_viol[0], "R10 sh_short", sh_short, m_viol);
      chk(ph_coarse == (m_ph == 1 || m_ph == 2), m_md ? "R7 coarse" : "R4 coarse", ph_coarse, m_ph);
      chk(ph_fine == (m_ph == 3), m_md ? "R7 fine" : "R4 fine", ph_fine, m_ph);
      chk(ph_latch == (m_ph == 4), "R4 latch", ph_latch, m_ph);
      chk($countones({ph_coarse, ph_fine, ph_latch}) <= 1 && (!ph_sample || ph_coarse),
          "R12 phases", {ph_sample, ph_coarse, ph_fine, ph_latch}, 0);
    end
    if (cycles > 20000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic tick(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic conv1(input int ch, input int len, input int res);
    chan_sel = ch[CHW-1:0]; result_in = res[DW-1:0];
    cs_n = 0; sh_n = 0; tick(len);
    sh_n = 1; cs_n = 1; tick(FC + 4);
    chk(int_n == 0, "R4 int low after conversion", int_n, 0);
    chk(chan == ch[CHW-1:0], "R3 captured channel", chan, ch);
    cs_n = 0; rd_n = 0; tick(2);
    chk(dbus == res[DW-1:0], "R9 new result readable", dbus, res);
    rd_n = 1; cs_n = 1; tick(2);
    chk(int_n == 1, "R5 int released by read", int_n, 1);
    last_res = res;
  endtask

  initial begin
    tick(2);
    go = 1;
    tick(1);
    rst = 0;
    tick(1);
    chk(int_n == 1 && overrun == 0 && sh_short == 0, "R1 reset state", int_n, 1);
    cs_n = 0; rd_n = 0; tick(1);
    chk(dbus_oe == 1 && dbus == 0, "R1 reset result", dbus, 0);
    rd_n = 1; cs_n = 1; tick(1);
    chk(dbus_oe == 0, "R6 bus released", dbus_oe, 0);

    chan_sel = 3; sh_n = 0; tick(4); sh_n = 1; rd_n = 0; tick(2); rd_n = 1; tick(8);
    chk(int_n == 1 && ph_coarse == 0 && chan == 0, "R2 strobes without select", chan, 0);

    conv1(2, 4, 'h2A5);
    conv1(1, 1, 'h0F0);
    chk(sh_short == 1, "R10 short sample flagged", sh_short, 1);
    conv1(0, 3, 'h3FF);

    tied = 1; chan_sel = 3; result_in = 'h155;
    cs_n = 0; sh_n = 0; rd_n = 0; tick(3);
    chk(ph_coarse == 1, "R7 timed coarse", ph_coarse, 1);
    chk(dbus == last_res[DW-1:0], "R8 previous result during conversion", dbus, last_res);
    tick(RC + RF + 8);
    chk(dbus == 'h155, "R8 new result after delay", dbus, 'h155);
    sh_n = 1; rd_n = 1; tick(2); cs_n = 1; tied = 0; tick(2);
    chk(int_n == 1, "R5 int released in read mode", int_n, 1);
    last_res = 'h155;

    chan_sel = 2; result_in = 'h0AA; cs_n = 0; sh_n = 0; tick(3);
    sh_n = 1; tick(2);
    chan_sel = 1; sh_n = 0; tick(1); sh_n = 1; tick(1);
    chk(overrun == 1, "R11 overrun set", overrun, 1);
    chk(chan == 2, "R11 channel kept", chan, 2);
    cs_n = 1; tick(FC + 4);
    cs_n = 0; rd_n = 0; tick(1);
    chk(dbus == 'h0AA, "R11 conversion unaffected", dbus, 'h0AA);
    rd_n = 1; cs_n = 1; tick(2);

    rst = 1; tick(2); rst = 0; tick(1);
    chk(int_n == 1 && overrun == 0 && sh_short == 0, "R1 flags cleared", overrun, 0);
    cs_n = 0; rd_n = 0; tick(1);
    chk(dbus == 0, "R1 result cleared", dbus, 0);
    rd_n = 1; cs_n = 1; tick(3);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule